// File: doc/BRIEF.md
# Ethernet L2 Header Parser

This block watches the first bytes of a received Ethernet frame. The frame arrives as a byte stream with a valid strobe and start and end markers. The block pulls out the two station addresses and the first type field. It then follows the frame inward through any stack of 802.1Q tags or MPLS label entries, or through an LLC header and a SNAP extension. When it has found where the network-layer header begins, it publishes a result record and raises a one-cycle done strobe.

The record holds the final protocol type, the outermost tag control word, flags that name the kind of encapsulation seen, and the byte offset of the layer-3 header. It also has flags for an overlong tag stack and for a frame that ended too early. A nonzero parse-depth input turns the parser on for a frame. With that input at zero, the frame passes through untouched and the record stays empty. Downstream classification logic samples the record on the done strobe.

Top module: `l2hp_parser`

## Requirements
- R1: When `cfg_depth` is zero at the start-of-frame byte, that frame raises no `res_done` and every flag output stays 0 until the next start of frame.
- R2: Frame bytes 0..5 form `res_dmac` and bytes 6..11 form `res_smac`, first byte in bits 47:40; `res_mac_vld` is set once byte 11 has arrived.
- R3: Bytes 12..13 (high byte first) are reported on `res_etype1` with `res_etype1_vld` set.
- R4: A type value of 0x8100 opens a 4-byte tag (2 control bytes, then the next 2-byte type). Tags are followed until a non-0x8100 type appears. `res_vlan` is set and `res_tci` holds the control word of the outermost tag. `res_final` holds the first non-tag type, and `res_l3_off` = 14 + 4 x tags.
- R5: A type of 0x8847 or 0x8848 opens 4-byte label entries whose bottom-of-stack bit is bit 0 of the entry's third byte. The parse ends after the entry with that bit set. `res_mpls` is set, `res_final` holds the MPLS type, and `res_l3_off` points just past that entry.
- R6: A type below 0x0600 is a length, and 3 LLC bytes follow (`res_llc` set). If they are AA AA 03, `res_snap` is set and 5 further bytes follow. The last two of these give `res_final`, and `res_l3_off` is then 22. Otherwise `res_final` is the length and `res_l3_off` is 17.
- R7: A fifth 0x8100 type after four tags, or eight label entries with no bottom-of-stack bit, ends the parse with `res_err` set and `res_final_vld` clear.
- R8: `res_done` is high for exactly one cycle, in the cycle after the byte that settles the parse (or after the end-of-frame byte). The record then holds until the next start of frame.
- R9: An end-of-frame byte that arrives before the parse settles gives a done with `res_trunc` set and `res_final_vld` clear. An end-of-frame marker on the settling byte itself is a normal completion.
- R10: `res_final_vld` is set only on normal completion, and `res_l3_off` then equals the number of frame bytes up to and including the settling byte.
- R11: After reset, `res_done` and every flag output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | DEPTH_W | Parse depth; zero disables parsing |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Frame byte |
| res_done | output | 1 | One-cycle result strobe |
| res_dmac | output | 48 | Destination address |
| res_smac | output | 48 | Source address |
| res_mac_vld | output | 1 | Both addresses captured |
| res_etype1 | output | 16 | First type field |
| res_etype1_vld | output | 1 | First type field captured |
| res_final | output | 16 | Final protocol type |
| res_final_vld | output | 1 | Parse completed normally |
| res_tci | output | 16 | Outermost tag control word |
| res_vlan | output | 1 | Tag control word valid |
| res_mpls | output | 1 | Label stack seen |
| res_llc | output | 1 | Length field / LLC seen |
| res_snap | output | 1 | SNAP extension seen |
| res_l3_off | output | OFF_W | Byte offset of the layer-3 header |
| res_err | output | 1 | Stack limit exceeded |
| res_trunc | output | 1 | Frame ended before the parse settled |

## Verification
Each frame format is tested: untagged, single and double tag, a two-entry label stack, SNAP, plain LLC, both stack-limit overflows, a frame cut off inside a tag, and one whose end marker falls on the settling byte. Each run checks the offset and the cycle of the done strobe. A design with an off-by-one in any walk loop would report a wrong offset or pulse a cycle late. A design that tested the wrong bit for bottom-of-stack would run into the label limit. A tag counter compared one step off would flag four legal tags as an error or accept a fifth.

Short frames of one and five bytes must produce a truncation done with the address flag clear. Parsing an end-of-frame on the deciding byte as truncation would show up on the last table entry. A disabled frame that follows an enabled one must clear the flags left over from before. A design that ignored the depth input, or kept stale flags, would show a done or a set flag.

// File: rtl/l2hp_pkg.sv
package l2hp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OFF,
    ST_MAC,
    ST_ETY,
    ST_VTCI,
    ST_VETY,
    ST_MPLS,
    ST_LLC,
    ST_SNAP,
    ST_WAIT
  } walk_st_e;

  localparam logic [15:0] TYPE_TAG     = 16'h8100;
  localparam logic [15:0] TYPE_MPLS_UC = 16'h8847;
  localparam logic [15:0] TYPE_MPLS_MC = 16'h8848;
  localparam logic [15:0] TYPE_MIN     = 16'h0600;
  localparam logic [23:0] SNAP_MARK    = 24'hAAAA03;
  localparam int          ADDR_BYTES   = 12;

endpackage

// File: rtl/l2hp_type_class.sv
module l2hp_type_class
  import l2hp_pkg::*;
(
  input  logic [15:0] word,
  input  logic [23:0] llc3,
  output logic        is_tag,
  output logic        is_mpls,
  output logic        is_len,
  output logic        is_snap
);

  always_comb begin
    is_tag  = (word == TYPE_TAG);
    is_mpls = (word == TYPE_MPLS_UC) || (word == TYPE_MPLS_MC);
    is_len  = (word < TYPE_MIN);
    is_snap = (llc3 == SNAP_MARK);
  end

endmodule

// File: rtl/l2hp_walk.sv
module l2hp_walk
  import l2hp_pkg::*;
#(
  parameter int DEPTH_W  = 2,
  parameter int MAX_VLAN = 4,
  parameter int MAX_MPLS = 8,
  parameter int OFF_W    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic [7:0]         in_data,
  output logic [15:0]        word,
  output logic               clr,
  output logic               mac_sh,
  output logic               mac_ok,
  output logic               ety1,
  output logic               tci_ld,
  output logic               fin_ld,
  output logic               set_mpls,
  output logic               set_llc,
  output logic               set_snap,
  output logic               fin,
  output logic               fin_ok,
  output logic               fin_err,
  output logic [OFF_W-1:0]   off_n
);

  localparam int VC_W = $clog2(MAX_VLAN + 1);
  localparam int MC_W = $clog2(MAX_MPLS);
  localparam logic [3:0]      SUB_ADDR_LAST = 4'(ADDR_BYTES - 1);
  localparam logic [VC_W-1:0] VC_MAX        = VC_W'(MAX_VLAN);
  localparam logic [VC_W-1:0] VC_ONE        = VC_W'(1);
  localparam logic [MC_W-1:0] MC_LAST       = MC_W'(MAX_MPLS - 1);

  walk_st_e         st_q, st_n;
  logic [3:0]       sub_q, sub_n;
  logic [VC_W-1:0]  vc_q, vc_n;
  logic [MC_W-1:0]  mc_q, mc_n;
  logic [OFF_W-1:0] pos_q, pos_n;
  logic             sbot_q, sbot_n;
  logic [15:0]      sh_q;
  logic             is_tag, is_mpls, is_len, is_snap;
  logic             en, in_parse;

  assign word  = {sh_q[7:0], in_data};
  assign off_n = pos_q + OFF_W'(1);
  assign en    = |cfg_depth;

  l2hp_type_class u_class (
    .word    (word),
    .llc3    ({sh_q, in_data}),
    .is_tag  (is_tag),
    .is_mpls (is_mpls),
    .is_len  (is_len),
    .is_snap (is_snap)
  );

  always_comb begin
    in_parse = st_q inside {ST_MAC, ST_ETY, ST_VTCI, ST_VETY, ST_MPLS, ST_LLC, ST_SNAP};
  end

  always_comb begin
    st_n     = st_q;
    sub_n    = sub_q;
    vc_n     = vc_q;
    mc_n     = mc_q;
    pos_n    = pos_q;
    sbot_n   = sbot_q;
    clr      = 1'b0;
    mac_sh   = 1'b0;
    mac_ok   = 1'b0;
    ety1     = 1'b0;
    tci_ld   = 1'b0;
    fin_ld   = 1'b0;
    set_mpls = 1'b0;
    set_llc  = 1'b0;
    set_snap = 1'b0;
    fin      = 1'b0;
    fin_ok   = 1'b0;
    fin_err  = 1'b0;
    if (in_valid) begin
      if (in_sof) begin
        clr   = 1'b1;
        vc_n  = '0;
        mc_n  = '0;
        sub_n = 4'd1;
        pos_n = OFF_W'(1);
        if (en) begin
          mac_sh = 1'b1;
          st_n   = ST_MAC;
          if (in_eof) begin
            fin  = 1'b1;
            st_n = ST_IDLE;
          end
        end else begin
          st_n = in_eof ? ST_IDLE : ST_OFF;
        end
      end else begin
        if (pos_q != '1) pos_n = pos_q + OFF_W'(1);
        sub_n = sub_q + 4'd1;
        case (st_q)
          ST_MAC: begin
            mac_sh = 1'b1;
            if (sub_q == SUB_ADDR_LAST) begin
              mac_ok = 1'b1;
              sub_n  = '0;
              st_n   = ST_ETY;
            end
          end
          ST_ETY, ST_VETY: begin
            if (sub_q[0]) begin
              sub_n = '0;
              if (st_q == ST_ETY) ety1 = 1'b1;
              if (is_tag) begin
                if (vc_q == VC_MAX) begin
                  fin     = 1'b1;
                  fin_err = 1'b1;
                end else begin
                  vc_n = vc_q + VC_ONE;
                  st_n = ST_VTCI;
                end
              end else begin
                fin_ld = 1'b1;
                if (is_mpls) begin
                  set_mpls = 1'b1;
                  st_n     = ST_MPLS;
                end else if (is_len) begin
                  set_llc = 1'b1;
                  st_n    = ST_LLC;
                end else begin
                  fin    = 1'b1;
                  fin_ok = 1'b1;
                end
              end
            end
          end
          ST_VTCI: begin
            if (sub_q[0]) begin
              if (vc_q == VC_ONE) tci_ld = 1'b1;
              sub_n = '0;
              st_n  = ST_VETY;
            end
          end
          ST_MPLS: begin
            if (sub_q == 4'd2) sbot_n = in_data[0];
            if (sub_q == 4'd3) begin
              sub_n = '0;
              if (sbot_q) begin
                fin    = 1'b1;
                fin_ok = 1'b1;
              end else if (mc_q == MC_LAST) begin
                fin     = 1'b1;
                fin_err = 1'b1;
              end else begin
                mc_n = mc_q + MC_W'(1);
              end
            end
          end
          ST_LLC: begin
            if (sub_q == 4'd2) begin
              sub_n = '0;
              if (is_snap) begin
                set_snap = 1'b1;
                st_n     = ST_SNAP;
              end else begin
                fin    = 1'b1;
                fin_ok = 1'b1;
              end
            end
          end
          ST_SNAP: begin
            if (sub_q == 4'd4) begin
              fin_ld = 1'b1;
              fin    = 1'b1;
              fin_ok = 1'b1;
            end
          end
          default: ;
        endcase
        if (in_parse) begin
          if (fin) begin
            st_n = in_eof ? ST_IDLE : ST_WAIT;
          end else if (in_eof) begin
            fin  = 1'b1;
            st_n = ST_IDLE;
          end
        end else if (in_eof) begin
          st_n = ST_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sub_q  <= '0;
      vc_q   <= '0;
      mc_q   <= '0;
      pos_q  <= '0;
      sbot_q <= 1'b0;
      sh_q   <= '0;
    end else if (in_valid) begin
      st_q   <= st_n;
      sub_q  <= sub_n;
      vc_q   <= vc_n;
      mc_q   <= mc_n;
      pos_q  <= pos_n;
      sbot_q <= sbot_n;
      sh_q   <= {sh_q[7:0], in_data};
    end
  end

endmodule

// File: rtl/l2hp_capture.sv
module l2hp_capture
  import l2hp_pkg::*;
#(
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_data,
  input  logic [15:0]      word,
  input  logic             clr,
  input  logic             mac_sh,
  input  logic             mac_ok,
  input  logic             ety1,
  input  logic             tci_ld,
  input  logic             fin_ld,
  input  logic             set_mpls,
  input  logic             set_llc,
  input  logic             set_snap,
  input  logic             fin,
  input  logic             fin_ok,
  input  logic             fin_err,
  input  logic [OFF_W-1:0] off_n,
  output logic             done,
  output logic [47:0]      dmac,
  output logic [47:0]      smac,
  output logic             mac_vld,
  output logic [15:0]      etype1,
  output logic             etype1_vld,
  output logic [15:0]      final_t,
  output logic             final_vld,
  output logic [15:0]      tci,
  output logic             vlan,
  output logic             mpls,
  output logic             llc,
  output logic             snap,
  output logic [OFF_W-1:0] l3_off,
  output logic             err,
  output logic             trunc
);

  localparam int SR_W = 8 * ADDR_BYTES;

  logic [SR_W-1:0] mac_sr;
  logic            trunc_hit;

  assign trunc_hit = fin & ~fin_ok & ~fin_err;
  assign dmac      = mac_sr[SR_W-1 -: 48];
  assign smac      = mac_sr[47:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      mac_sr     <= '0;
      mac_vld    <= 1'b0;
      etype1     <= '0;
      etype1_vld <= 1'b0;
      final_t    <= '0;
      final_vld  <= 1'b0;
      tci        <= '0;
      vlan       <= 1'b0;
      mpls       <= 1'b0;
      llc        <= 1'b0;
      snap       <= 1'b0;
      l3_off     <= '0;
      err        <= 1'b0;
      trunc      <= 1'b0;
    end else begin
      done <= fin;
      if (mac_sh) mac_sr <= {mac_sr[SR_W-9:0], in_data};
      if (clr) begin
        mac_vld    <= 1'b0;
        etype1_vld <= 1'b0;
        final_vld  <= 1'b0;
        vlan       <= 1'b0;
        mpls       <= 1'b0;
        llc        <= 1'b0;
        snap       <= 1'b0;
        err        <= 1'b0;
        trunc      <= 1'b0;
      end
      if (mac_ok) mac_vld <= 1'b1;
      if (ety1) begin
        etype1     <= word;
        etype1_vld <= 1'b1;
      end
      if (tci_ld) begin
        tci  <= word;
        vlan <= 1'b1;
      end
      if (fin_ld)   final_t <= word;
      if (set_mpls) mpls    <= 1'b1;
      if (set_llc)  llc     <= 1'b1;
      if (set_snap) snap    <= 1'b1;
      if (fin_ok) begin
        final_vld <= 1'b1;
        l3_off    <= off_n;
      end
      if (fin_err)   err   <= 1'b1;
      if (trunc_hit) trunc <= 1'b1;
    end
  end

endmodule

// File: rtl/l2hp_parser.sv
module l2hp_parser
  import l2hp_pkg::*;
#(
  parameter int DEPTH_W  = 2,
  parameter int MAX_VLAN = 4,
  parameter int MAX_MPLS = 8,
  parameter int OFF_W    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic [7:0]         in_data,
  output logic               res_done,
  output logic [47:0]        res_dmac,
  output logic [47:0]        res_smac,
  output logic               res_mac_vld,
  output logic [15:0]        res_etype1,
  output logic               res_etype1_vld,
  output logic [15:0]        res_final,
  output logic               res_final_vld,
  output logic [15:0]        res_tci,
  output logic               res_vlan,
  output logic               res_mpls,
  output logic               res_llc,
  output logic               res_snap,
  output logic [OFF_W-1:0]   res_l3_off,
  output logic               res_err,
  output logic               res_trunc
);

  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic [15:0]      word;
  logic             clr, mac_sh, mac_ok, ety1, tci_ld, fin_ld;
  logic             set_mpls, set_llc, set_snap, fin, fin_ok, fin_err;
  logic [OFF_W-1:0] off_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  l2hp_walk #(
    .DEPTH_W  (DEPTH_W),
    .MAX_VLAN (MAX_VLAN),
    .MAX_MPLS (MAX_MPLS),
    .OFF_W    (OFF_W)
  ) u_walk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_depth(cfg_depth),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .in_data  (in_data),
    .word     (word),
    .clr      (clr),
    .mac_sh   (mac_sh),
    .mac_ok   (mac_ok),
    .ety1     (ety1),
    .tci_ld   (tci_ld),
    .fin_ld   (fin_ld),
    .set_mpls (set_mpls),
    .set_llc  (set_llc),
    .set_snap (set_snap),
    .fin      (fin),
    .fin_ok   (fin_ok),
    .fin_err  (fin_err),
    .off_n    (off_n)
  );

  l2hp_capture #(
    .OFF_W (OFF_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_data   (in_data),
    .word      (word),
    .clr       (clr),
    .mac_sh    (mac_sh),
    .mac_ok    (mac_ok),
    .ety1      (ety1),
    .tci_ld    (tci_ld),
    .fin_ld    (fin_ld),
    .set_mpls  (set_mpls),
    .set_llc   (set_llc),
    .set_snap  (set_snap),
    .fin       (fin),
    .fin_ok    (fin_ok),
    .fin_err   (fin_err),
    .off_n     (off_n),
    .done      (res_done),
    .dmac      (res_dmac),
    .smac      (res_smac),
    .mac_vld   (res_mac_vld),
    .etype1    (res_etype1),
    .etype1_vld(res_etype1_vld),
    .final_t   (res_final),
    .final_vld (res_final_vld),
    .tci       (res_tci),
    .vlan      (res_vlan),
    .mpls      (res_mpls),
    .llc       (res_llc),
    .snap      (res_snap),
    .l3_off    (res_l3_off),
    .err       (res_err),
    .trunc     (res_trunc)
  );

endmodule

// File: rtl/l2hp_checker.sv
module l2hp_checker #(
  parameter int DEPTH_W = 2,
  parameter int OFF_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DEPTH_W-1:0] cfg_depth,
  input logic               in_valid,
  input logic               in_sof,
  input logic               in_eof,
  input logic               res_done,
  input logic               res_mac_vld,
  input logic [15:0]        res_etype1,
  input logic               res_etype1_vld,
  input logic [15:0]        res_final,
  input logic               res_final_vld,
  input logic               res_vlan,
  input logic               res_mpls,
  input logic               res_llc,
  input logic               res_snap,
  input logic [OFF_W-1:0]   res_l3_off,
  input logic               res_err,
  input logic               res_trunc
);

  logic off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= 1'b0;
    else if (in_valid && in_sof) off_q <= (cfg_depth == '0);
  end

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> (!res_done && !res_mac_vld && !res_etype1_vld && !res_final_vld &&
               !res_vlan && !res_mpls && !res_llc && !res_err && !res_trunc));

  assert_tag_type_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_vlan |-> (res_etype1_vld && res_etype1 == 16'h8100));

  assert_mpls_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_mpls |-> (res_final == 16'h8847 || res_final == 16'h8848));

  assert_snap_in_llc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_snap |-> res_llc);

  assert_trunc_after_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_trunc) |-> $past(in_valid && in_eof));

  assert_final_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_final_vld |-> (!res_err && !res_trunc));

  assert_min_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_final_vld |-> (res_l3_off >= OFF_W'(14)));

endmodule

bind l2hp_parser l2hp_checker #(.DEPTH_W(DEPTH_W), .OFF_W(OFF_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_depth     (cfg_depth),
  .in_valid      (in_valid),
  .in_sof        (in_sof),
  .in_eof        (in_eof),
  .res_done      (res_done),
  .res_mac_vld   (res_mac_vld),
  .res_etype1    (res_etype1),
  .res_etype1_vld(res_etype1_vld),
  .res_final     (res_final),
  .res_final_vld (res_final_vld),
  .res_vlan      (res_vlan),
  .res_mpls      (res_mpls),
  .res_llc       (res_llc),
  .res_snap      (res_snap),
  .res_l3_off    (res_l3_off),
  .res_err       (res_err),
  .res_trunc     (res_trunc)
);

// File: tb/l2hp_parser_tb.sv
module l2hp_parser_tb_top;

  localparam int NV = 10;
  localparam logic [47:0] DM = 48'h001122334455;
  localparam logic [47:0] SM = 48'h66778899AABB;

  // tail bytes after the addresses, right-justified; flags {vlan,mpls,llc,snap,err,trunc,final_vld}
  localparam logic [319:0] TAIL [NV] = '{
    320'h08004500,
    320'h8100A123080045,
    320'h8100200581003006_86DD60,
    320'h8847_00011040_00022140_45,
    320'h0030_AAAA03_000000_0806_00,
    320'h0026_424203_00,
    320'h8100000181000002_8100000381000004_8100000545,
    320'h8848_00000040_00000040_00000040_00000040_00000040_00000040_00000040_00000040_45,
    320'h810012,
    320'h86DD
  };
  localparam int          TLEN [NV] = '{4, 7, 11, 11, 11, 6, 21, 35, 3, 2};
  localparam logic [15:0] XE1  [NV] = '{16'h0800, 16'h8100, 16'h8100, 16'h8847, 16'h0030,
                                        16'h0026, 16'h8100, 16'h8848, 16'h8100, 16'h86DD};
  localparam logic [15:0] XFIN [NV] = '{16'h0800, 16'h0800, 16'h86DD, 16'h8847, 16'h0806,
                                        16'h0026, 16'h0000, 16'h0000, 16'h0000, 16'h86DD};
  localparam logic [15:0] XTCI [NV] = '{16'h0, 16'hA123, 16'h2005, 16'h0, 16'h0,
                                        16'h0, 16'h0001, 16'h0, 16'h0, 16'h0};
  localparam int          XOFF [NV] = '{14, 18, 22, 22, 22, 17, 0, 0, 0, 14};
  localparam logic [6:0]  XFLG [NV] = '{7'b0000001, 7'b1000001, 7'b1000001, 7'b0100001,
                                        7'b0011001, 7'b0010001, 7'b1000100, 7'b0100100,
                                        7'b0000010, 7'b0000001};

  logic        clk, rst_n;
  logic [1:0]  cfg_depth;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        res_done, res_mac_vld, res_etype1_vld, res_final_vld, res_vlan;
  logic        res_mpls, res_llc, res_snap, res_err, res_trunc;
  logic [47:0] res_dmac, res_smac;
  logic [15:0] res_etype1, res_final, res_tci;
  logic [6:0]  res_l3_off;

  int checks, fails, dones, done_at, cyc;

  l2hp_parser dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .res_done(res_done),
    .res_dmac(res_dmac), .res_smac(res_smac), .res_mac_vld(res_mac_vld),
    .res_etype1(res_etype1), .res_etype1_vld(res_etype1_vld), .res_final(res_final),
    .res_final_vld(res_final_vld), .res_tci(res_tci), .res_vlan(res_vlan),
    .res_mpls(res_mpls), .res_llc(res_llc), .res_snap(res_snap),
    .res_l3_off(res_l3_off), .res_err(res_err), .res_trunc(res_trunc)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog R8 actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [319:0] t, input int len, input int k);
    if (k < 6)       return DM[8*(5-k) +: 8];
    else if (k < 12) return SM[8*(11-k) +: 8];
    else             return t[8*(len-1-(k-12)) +: 8];
  endfunction

  // sends the frame, cut to 'total' bytes; counts done strobes and where they came
  task automatic send_frame(input logic [319:0] t, input int len, input int total, input logic [1:0] dep);
    dones   = 0;
    done_at = -1;
    cfg_depth = dep;
    for (int k = 0; k < total; k++) begin
      in_valid = 1'b1;
      in_sof   = (k == 0);
      in_eof   = (k == total - 1);
      in_data  = fbyte(t, len, k);
      @(negedge clk);
      if (res_done) begin dones++; done_at = k; end
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eof   = 1'b0;
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (res_done) begin dones++; done_at = 1000 + k; end
    end
  endtask

  function automatic logic [6:0] flags();
    return {res_vlan, res_mpls, res_llc, res_snap, res_err, res_trunc, res_final_vld};
  endfunction

  initial begin
    clk = 1'b0; rst_n = 1'b0; cfg_depth = 2'd1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    checks = 0; fails = 0; cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(!res_done, "R11 done after reset", 64'(res_done), 0);
    chk(flags() == 7'd0 && !res_mac_vld && !res_etype1_vld, "R11 flags after reset",
        64'({flags(), res_mac_vld, res_etype1_vld}), 0);

    for (int v = 0; v < NV; v++) begin
      int n;
      n = 12 + TLEN[v];
      send_frame(TAIL[v], TLEN[v], n, 2'd2);
      chk(dones == 1, $sformatf("R8 vec%0d done count", v), 64'(dones), 1);
      if (XFLG[v][0])
        chk(done_at == XOFF[v] - 1, $sformatf("R8 vec%0d done cycle", v), 64'(done_at), 64'(XOFF[v] - 1));
      if (XFLG[v][1])
        chk(done_at == n - 1, $sformatf("R9 vec%0d done cycle", v), 64'(done_at), 64'(n - 1));
      chk(res_mac_vld && res_dmac == DM && res_smac == SM, $sformatf("R2 vec%0d addresses", v),
          {res_dmac[31:0], res_smac[31:0]}, {DM[31:0], SM[31:0]});
      chk(res_etype1_vld && res_etype1 == XE1[v], $sformatf("R3 vec%0d first type", v),
          64'(res_etype1), 64'(XE1[v]));
      chk(flags() == XFLG[v], $sformatf("R4/R5/R6/R7/R9 vec%0d flags", v), 64'(flags()), 64'(XFLG[v]));
      if (XFLG[v][0]) begin
        chk(res_final == XFIN[v], $sformatf("R4/R5/R6 vec%0d final type", v), 64'(res_final), 64'(XFIN[v]));
        chk(res_l3_off == 7'(XOFF[v]), $sformatf("R10 vec%0d l3 offset", v), 64'(res_l3_off), 64'(XOFF[v]));
      end
      if (XFLG[v][6])
        chk(res_tci == XTCI[v], $sformatf("R4 vec%0d tci", v), 64'(res_tci), 64'(XTCI[v]));
    end

    // R1: disabled frame after an enabled one clears flags and gives no done
    send_frame(TAIL[1], TLEN[1], 12 + TLEN[1], 2'd3);
    chk(res_vlan, "R4 tagged frame before disable", 64'(res_vlan), 1);
    send_frame(TAIL[1], TLEN[1], 12 + TLEN[1], 2'd0);
    chk(dones == 0, "R1 no done when disabled", 64'(dones), 0);
    chk(flags() == 7'd0 && !res_mac_vld && !res_etype1_vld, "R1 flags clear when disabled",
        64'({flags(), res_mac_vld, res_etype1_vld}), 0);

    // R9: five-byte frame ends before the addresses complete
    send_frame(TAIL[0], TLEN[0], 5, 2'd1);
    chk(dones == 1 && done_at == 4, "R9 short frame done", 64'(done_at), 4);
    chk(res_trunc && !res_mac_vld && !res_final_vld, "R9 short frame flags",
        64'({res_trunc, res_mac_vld, res_final_vld}), 64'(3'b100));

    // R9: single byte carrying both markers
    send_frame(TAIL[0], TLEN[0], 1, 2'd1);
    chk(dones == 1 && done_at == 0, "R9 one-byte frame done", 64'(done_at), 0);
    chk(flags() == 7'b0000010, "R9 one-byte frame flags", 64'(flags()), 64'(7'b0000010));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule